// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Cause and Mask

This block holds two independent 32-bit down counters behind a small register bus. A single control word gives each counter a run bit and a reload bit. With reload set, a counter reaches zero, reloads from its reload register and keeps running, so a reload value of N-1 gives a period of N clocks. With reload clear, the counter runs down once, raises its event, parks at zero and clears its own run bit.

Each expiry latches a bit in an interrupt cause register, whether or not that bit is masked. A mask register gates the latched causes onto one interrupt line. Software acknowledges a cause by writing 0 to its bit. Writing 1 leaves the bit as it is, so one timer can be acknowledged without disturbing the other. A typical use keeps one counter free-running as a time base and runs the other as an event source, either one-shot or periodic.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads 0, both counters are stopped and irq_o is low. A read of an unmapped offset returns 0. Reads return 0 while req_i is low.
- R2: Control word at offset 0x000: bit 0 runs counter 0, bit 1 is reload for counter 0, bit 2 runs counter 1, bit 3 is reload for counter 1. A running counter decrements by one on every clock, and its value register (0x014 for counter 0, 0x01C for counter 1) returns the live count, combinationally, in the same cycle as the read.
- R3: A write to a value register loads the count directly, whatever the reload register holds. The reload registers sit at 0x010 and 0x018 and read back as written.
- R4: A running counter with reload set expires on the clock where its count is 0, loads the reload value on that edge and keeps running, giving a period of reload+1 clocks. Its run bit stays set.
- R5: A running counter with reload clear expires on the clock where its count is 0. It then holds 0, and its run bit in the control word reads 0 afterwards.
- R6: An expiry of counter 0 sets cause bit 1 and an expiry of counter 1 sets cause bit 2 of the cause register at 0x110, regardless of the mask.
- R7: irq_o is high exactly when some cause bit is set and the same bit of the mask register at 0x114 is set.
- R8: A cause bit is cleared by writing 0 to its position. Writing 1 to it leaves it unchanged.
- R9: When an expiry and a clearing write hit the same cause bit in the same cycle, the bit stays set.
- R10: A counter whose run bit is clear holds its count and raises no expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; each rising edge is one count tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (12) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid in the same cycle as the read strobe |
| irq_o | output | 1 | Masked interrupt output |

## Verification
The assertions assume that each bus access lasts exactly one cycle. They also assume that a write to a value register wins over counting in that cycle. The one-shot self-clear is only checked on cycles with no control write, because software may rewrite the run bit in that cycle. The stimulus drives every access for a single clock, applies it away from the edge, and times each control write so that it never lands on a cycle where a one-shot counter is at zero.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int unsigned NTIM = 2;

  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_RLD0  = 12'h010;
  localparam logic [11:0] OFF_VAL0  = 12'h014;
  localparam logic [11:0] OFF_CAUSE = 12'h110;
  localparam logic [11:0] OFF_MASK  = 12'h114;
  localparam logic [11:0] TIM_STRIDE = 12'h008;

  function automatic logic [11:0] rld_off(input int unsigned idx);
    return OFF_RLD0 + TIM_STRIDE * 12'(idx);
  endfunction

  function automatic logic [11:0] val_off(input int unsigned idx);
    return OFF_VAL0 + TIM_STRIDE * 12'(idx);
  endfunction

  // cause/mask bit position of a timer
  function automatic int unsigned irq_bit(input int unsigned idx);
    return idx + 1;
  endfunction

  // control word field positions
  function automatic int unsigned run_bit(input int unsigned idx);
    return 2 * idx;
  endfunction

  function automatic int unsigned rld_bit(input int unsigned idx);
    return 2 * idx + 1;
  endfunction
endpackage

// File: rtl/dtim_counter.sv
module dtim_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         rld_en_i,
  input  logic         rld_wr_i,
  input  logic         val_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, rld_q;
  logic         at_zero;

  assign at_zero  = (cnt_q == '0);
  // a direct load wins over counting in the same cycle
  assign expire_o = run_i && at_zero && !val_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rld_q <= '0;
    else if (rld_wr_i) rld_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (val_wr_i) begin
      cnt_q <= wdata_i;
    end else if (run_i) begin
      if (!at_zero)      cnt_q <= cnt_q - 1'b1;
      else if (rld_en_i) cnt_q <= rld_q;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !val_wr_i && !at_zero |=> cnt_q == $past(cnt_q) - 1'b1); // R2
  AST_VAL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_wr_i |=> cnt_q == $past(wdata_i)); // R3
  AST_PERIOD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && rld_en_i && at_zero && !val_wr_i |=> cnt_q == $past(rld_q)); // R4
  AST_ONESHOT_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !rld_en_i && at_zero && !val_wr_i |=> cnt_q == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !val_wr_i |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/dtim_ctrl.sv
module dtim_ctrl #(
  parameter int unsigned W    = 32,
  parameter int unsigned NTIM = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [NTIM-1:0] done_i,
  output logic [NTIM-1:0] run_o,
  output logic [NTIM-1:0] rld_en_o,
  output logic [W-1:0]    word_o
);
  import dtim_pkg::*;

  logic [NTIM-1:0] run_q, rld_q;

  for (genvar i = 0; i < NTIM; i++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q[i] <= 1'b0;
        rld_q[i] <= 1'b0;
      end else if (wr_i) begin
        run_q[i] <= wdata_i[run_bit(i)];
        rld_q[i] <= wdata_i[rld_bit(i)];
      end else if (done_i[i]) begin
        run_q[i] <= 1'b0;
      end
    end

    AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[i] && !wr_i |=> !run_q[i]); // R5
  end

  always_comb begin
    word_o = '0;
    for (int unsigned i = 0; i < NTIM; i++) begin
      word_o[run_bit(i)] = run_q[i];
      word_o[rld_bit(i)] = rld_q[i];
    end
  end

  assign run_o    = run_q;
  assign rld_en_o = rld_q;
endmodule

// File: rtl/dtim_irq.sv
module dtim_irq #(
  parameter int unsigned W    = 32,
  parameter int unsigned NTIM = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NTIM-1:0] expire_i,
  input  logic            cause_wr_i,
  input  logic            mask_wr_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    cause_o,
  output logic [W-1:0]    mask_o,
  output logic            irq_o
);
  import dtim_pkg::*;

  logic [NTIM-1:0] cause_q, mask_q;

  for (genvar i = 0; i < NTIM; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cause_q[i] <= 1'b0;
      else if (expire_i[i])                       cause_q[i] <= 1'b1;
      else if (cause_wr_i && !wdata_i[irq_bit(i)]) cause_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q[i] <= 1'b0;
      else if (mask_wr_i) mask_q[i] <= wdata_i[irq_bit(i)];
    end

    AST_EXPIRY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[i] |=> cause_q[i]); // R9
    AST_ONE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cause_wr_i && wdata_i[irq_bit(i)] && !expire_i[i] |=> $stable(cause_q[i])); // R8
    AST_ZERO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cause_wr_i && !wdata_i[irq_bit(i)] && !expire_i[i] |=> !cause_q[i]); // R8
  end

  always_comb begin
    cause_o = '0;
    mask_o  = '0;
    for (int unsigned i = 0; i < NTIM; i++) begin
      cause_o[irq_bit(i)] = cause_q[i];
      mask_o[irq_bit(i)]  = mask_q[i];
    end
  end

  assign irq_o = |(cause_q & mask_q);
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import dtim_pkg::*;

  localparam int unsigned NT = NTIM;

  logic              wr, rd;
  logic [11:0]       off;
  logic [NT-1:0]     run, rld_en, expire, done, rld_wr, val_wr;
  logic [DATA_W-1:0] cnt [NT];
  logic [DATA_W-1:0] rld [NT];
  logic [DATA_W-1:0] ctrl_word, cause_word, mask_word;

  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;
  assign off = 12'(addr_i);

  dtim_ctrl #(.W(DATA_W), .NTIM(NT)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr && off == OFF_CTRL),
    .wdata_i  (wdata_i),
    .done_i   (done),
    .run_o    (run),
    .rld_en_o (rld_en),
    .word_o   (ctrl_word)
  );

  for (genvar i = 0; i < NT; i++) begin : g_cnt
    assign rld_wr[i] = wr && off == rld_off(i);
    assign val_wr[i] = wr && off == val_off(i);
    assign done[i]   = expire[i] && !rld_en[i];

    dtim_counter #(.W(DATA_W)) i_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run[i]),
      .rld_en_i (rld_en[i]),
      .rld_wr_i (rld_wr[i]),
      .val_wr_i (val_wr[i]),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt[i]),
      .rld_o    (rld[i]),
      .expire_o (expire[i])
    );

    AST_NO_EXPIRY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run[i] |-> !expire[i]); // R10
  end

  dtim_irq #(.W(DATA_W), .NTIM(NT)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .cause_wr_i (wr && off == OFF_CAUSE),
    .mask_wr_i  (wr && off == OFF_MASK),
    .wdata_i    (wdata_i),
    .cause_o    (cause_word),
    .mask_o     (mask_word),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (off == OFF_CTRL)  rdata_o = ctrl_word;
      if (off == OFF_CAUSE) rdata_o = cause_word;
      if (off == OFF_MASK)  rdata_o = mask_word;
      for (int unsigned i = 0; i < NT; i++) begin
        if (off == rld_off(i)) rdata_o = rld[i];
        if (off == val_off(i)) rdata_o = cnt[i];
      end
    end
  end

  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (cause_word & mask_word) != '0); // R7
endmodule

// File: tb/test_dual_timer.sv
module test_dual_timer;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam int unsigned NV = 60;

  // {op[1:0], addr[11:0], data[31:0], expect[31:0], req_tag[3:0]}
  // op: 0 write, 1 read and compare, 2 idle data cycles, 3 compare irq_o
  localparam logic [81:0] VEC [NV] = '{
    {2'd1, 12'h000, 32'h0, 32'h0, 4'd1},        // R1 control
    {2'd1, 12'h114, 32'h0, 32'h0, 4'd1},        // R1 mask
    {2'd1, 12'h110, 32'h0, 32'h0, 4'd1},        // R1 cause
    {2'd1, 12'h014, 32'h0, 32'h0, 4'd1},        // R1 value 0
    {2'd3, 12'h000, 32'h0, 32'h0, 4'd1},        // R1 irq low
    {2'd0, 12'h014, 32'd5, 32'h0, 4'd3},        // R3 load count 5
    {2'd0, 12'h000, 32'h1, 32'h0, 4'd2},        // R2 run counter 0 one-shot
    {2'd1, 12'h014, 32'h0, 32'd5, 4'd2},
    {2'd1, 12'h014, 32'h0, 32'd4, 4'd2},
    {2'd2, 12'h000, 32'd3, 32'h0, 4'd2},
    {2'd1, 12'h014, 32'h0, 32'd0, 4'd5},        // R5 expires this edge
    {2'd1, 12'h014, 32'h0, 32'd0, 4'd5},        // R5 parked
    {2'd1, 12'h000, 32'h0, 32'h0, 4'd5},        // R5 run bit cleared
    {2'd1, 12'h110, 32'h0, 32'h2, 4'd6},        // R6 bit 1 though masked
    {2'd3, 12'h000, 32'h0, 32'h0, 4'd7},        // R7 masked
    {2'd0, 12'h114, 32'h2, 32'h0, 4'd7},
    {2'd3, 12'h000, 32'h0, 32'h1, 4'd7},        // R7 unmasked
    {2'd0, 12'h110, 32'hFFFF_FFFF, 32'h0, 4'd8},
    {2'd1, 12'h110, 32'h0, 32'h2, 4'd8},        // R8 ones keep
    {2'd0, 12'h110, 32'hFFFF_FFFD, 32'h0, 4'd8},
    {2'd1, 12'h110, 32'h0, 32'h0, 4'd8},        // R8 zero clears
    {2'd3, 12'h000, 32'h0, 32'h0, 4'd7},
    {2'd0, 12'h018, 32'd2, 32'h0, 4'd4},
    {2'd0, 12'h01C, 32'd2, 32'h0, 4'd4},
    {2'd0, 12'h000, 32'hC, 32'h0, 4'd4},        // R4 counter 1 periodic
    {2'd1, 12'h01C, 32'h0, 32'd2, 4'd4},
    {2'd1, 12'h01C, 32'h0, 32'd1, 4'd4},
    {2'd1, 12'h01C, 32'h0, 32'd0, 4'd4},
    {2'd1, 12'h01C, 32'h0, 32'd2, 4'd4},        // R4 reloaded
    {2'd1, 12'h110, 32'h0, 32'h4, 4'd6},        // R6 bit 2
    {2'd3, 12'h000, 32'h0, 32'h0, 4'd7},        // R7 bit 2 masked
    {2'd1, 12'h01C, 32'h0, 32'd2, 4'd4},        // R4 period 3
    {2'd2, 12'h000, 32'd1, 32'h0, 4'd4},
    {2'd0, 12'h110, 32'hFFFF_FFFB, 32'h0, 4'd9}, // R9 clear meets expiry
    {2'd1, 12'h110, 32'h0, 32'h4, 4'd9},
    {2'd0, 12'h110, 32'hFFFF_FFFB, 32'h0, 4'd8},
    {2'd1, 12'h110, 32'h0, 32'h0, 4'd8},
    {2'd1, 12'h110, 32'h0, 32'h4, 4'd6},
    {2'd0, 12'h000, 32'h0, 32'h0, 4'd10},
    {2'd1, 12'h01C, 32'h0, 32'd0, 4'd10},       // R10 stopped
    {2'd1, 12'h01C, 32'h0, 32'd0, 4'd10},       // R10 holds, no reload
    {2'd1, 12'h000, 32'h0, 32'h0, 4'd10},
    {2'd1, 12'h018, 32'h0, 32'd2, 4'd3},
    {2'd0, 12'h01C, 32'h100, 32'h0, 4'd3},
    {2'd1, 12'h01C, 32'h0, 32'h100, 4'd3},      // R3 direct load
    {2'd1, 12'h018, 32'h0, 32'd2, 4'd3},        // R3 reload untouched
    {2'd1, 12'h020, 32'h0, 32'h0, 4'd1},        // R1 unmapped
    {2'd1, 12'h200, 32'h0, 32'h0, 4'd1},
    {2'd0, 12'h114, 32'h6, 32'h0, 4'd7},
    {2'd3, 12'h000, 32'h0, 32'h1, 4'd7},
    {2'd0, 12'h110, 32'hFFFF_FFF9, 32'h0, 4'd8},
    {2'd3, 12'h000, 32'h0, 32'h0, 4'd8},
    {2'd0, 12'h010, 32'd1, 32'h0, 4'd4},
    {2'd0, 12'h014, 32'd1, 32'h0, 4'd4},
    {2'd0, 12'h000, 32'h3, 32'h0, 4'd4},        // R4 counter 0 periodic
    {2'd1, 12'h014, 32'h0, 32'd1, 4'd4},
    {2'd1, 12'h014, 32'h0, 32'd0, 4'd4},
    {2'd1, 12'h014, 32'h0, 32'd1, 4'd4},
    {2'd1, 12'h110, 32'h0, 32'h2, 4'd6},
    {2'd1, 12'h000, 32'h0, 32'h3, 4'd4}         // R4 run bit kept
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  dual_timer #(.DATA_W(DW), .ADDR_W(AW)) i_dual_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [81:0] v);
    logic [1:0]  op;
    logic [11:0] a;
    logic [31:0] d, e;
    logic [3:0]  t;
    {op, a, d, e, t} = v;
    @(negedge clk_i);
    addr_i  = a;
    wdata_i = d;
    case (op)
      2'd0: begin req_i = 1'b1; we_i = 1'b1; end
      2'd1: begin
        req_i = 1'b1; we_i = 1'b0;
        #1 check(rdata_o, e, $sformatf("R%0d read %h", t, a));
      end
      2'd2: begin
        req_i = 1'b0; we_i = 1'b0;
        repeat (int'(d) - 1) @(negedge clk_i);
      end
      default: begin
        req_i = 1'b0; we_i = 1'b0;
        #1 check({31'h0, irq_o}, e, $sformatf("R%0d irq", t));
      end
    endcase
  endtask

  task automatic rd_now(input logic [11:0] a, input logic [31:0] e, input string tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 check(rdata_o, e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int unsigned k = 0; k < NV; k++) apply(VEC[k]);

    // R1: asynchronous reset in the middle of a periodic run with irq pending
    @(negedge clk_i);
    req_i = 1'b0;
    #1 check({31'h0, irq_o}, 32'h1, "R7 irq before reset");
    rst_ni = 1'b0;
    #1 check({31'h0, irq_o}, 32'h0, "R1 irq cleared by reset");
    rd_now(12'h000, 32'h0, "R1 control after reset");
    rd_now(12'h014, 32'h0, "R1 value after reset");
    rd_now(12'h010, 32'h0, "R1 reload after reset");
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    rd_now(12'h014, 32'h0, "R10 no counting after reset");
    req_i = 1'b0; we_i = 1'b0;
    #1 check(rdata_o, 32'h0, "R1 idle bus reads zero");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule